// File: doc/BRIEF.md
# Double-Precision to Integer Converter

This block turns a 64-bit IEEE 754 double into a 32-bit or 64-bit integer. The target can be signed or unsigned. Rounding is either forced toward zero or follows a two-bit rounding mode supplied with the request. A request is a single-cycle `start` pulse that carries the operand and the options. The block then works through the operand over several cycles and returns the integer with two flags. One flag reports an inexact result. The other reports an invalid conversion, which covers a NaN operand and a value that does not fit the target.

Internally the operand is unpacked into a sign, a 64-bit magnitude register and a shift count. A shifter moves the magnitude a few bits per cycle into integer alignment. Bits shifted out below the binary point collect into a guard bit and a sticky bit. A final combinational stage rounds, checks the range against the selected target and saturates when needed. The flag rules are strict. A value that overflows only after rounding reports invalid alone. A negative value that rounds to zero for an unsigned target reports inexact alone.

Top module: `fp2i_convert`

## Requirements
- R1: `fmt` selects the target: 2'b00 signed 32-bit, 2'b01 unsigned 32-bit, 2'b10 signed 64-bit, 2'b11 unsigned 64-bit. When `trunc` is 1 the value is rounded toward zero whatever `rmode` holds.
- R2: When `trunc` is 0, `rmode` selects the rounding: 2'b00 nearest with ties to even, 2'b01 toward zero, 2'b10 toward +infinity, 2'b11 toward -infinity.
- R3: An infinity, or a value whose rounded magnitude lies outside the target range, sets `invalid` and clears `inexact`. The result saturates to the target maximum for a positive sign and to the target minimum for a negative sign.
- R4: For an unsigned target, a negative value that rounds to zero returns 0, sets `inexact` and clears `invalid`.
- R5: Otherwise `inexact` is 1 exactly when nonzero fraction bits were discarded, and `invalid` is 0.
- R6: A NaN operand sets `invalid` and clears `inexact`. A signed target returns its most negative value and an unsigned target returns 0.
- R7: A 32-bit result appears on the 64-bit `result` port. It is sign-extended for the signed target and zero-extended for the unsigned target.
- R8: `busy` rises on the cycle after an accepted `start` and stays high until `done` pulses for one cycle; `busy` is low in the cycle `done` is high. `busy` lasts at most ceil(53/STEP)+1 cycles.
- R9: A `start` seen while `busy` is high is ignored. `result`, `inexact` and `invalid` hold their values except in the cycle that `done` rises.
- R10: After reset `busy`, `done`, `result`, `inexact` and `invalid` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, accepted while not busy |
| op | input | 64 | Double-precision operand |
| fmt | input | 2 | Target format select |
| trunc | input | 1 | 1 forces rounding toward zero |
| rmode | input | 2 | Rounding mode used when trunc is 0 |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Integer result, held until the next completion |
| inexact | output | 1 | Discarded fraction bits were nonzero |
| invalid | output | 1 | NaN or out-of-range conversion |

## Verification
The guard bit, the sticky bit, the shift count and the captured options all feed the `done` cycle of that one request. A fault in any of them shows at the ports when `done` next pulses. It does not show earlier, because the outputs are only updated on that cycle. A wrong count shifts the result by powers of two, or makes the busy time longer than the bound. A lost sticky bit drops `inexact` or picks the wrong side of a tie. A mis-captured format or sign gives the wrong saturation value or the wrong extension of the upper word. The test values therefore cover exact ties, values just below a boundary that rounding pushes over it, tiny negative values, and operands that need the maximum shift in each direction.

// File: rtl/fp2i_pkg.sv
package fp2i_pkg;

   localparam int FP_W   = 64;
   localparam int EXP_W  = 11;
   localparam int FRAC_W = 52;
   localparam int BIAS   = 1023;
   localparam int INT_W  = 64;
   localparam int HALF_W = INT_W / 2;
   localparam int MANT_W = FRAC_W + 1;
   localparam int MAX_SHIFT = FRAC_W + 1;
   localparam int CNT_W  = $clog2(MAX_SHIFT + 1);
   localparam int EW     = EXP_W + 2;

   typedef enum logic [1:0] {
      FMT_S32 = 2'b00,
      FMT_U32 = 2'b01,
      FMT_S64 = 2'b10,
      FMT_U64 = 2'b11
   } fmt_e;

   typedef enum logic [1:0] {
      RM_NEAR = 2'b00,
      RM_ZERO = 2'b01,
      RM_UP   = 2'b10,
      RM_DOWN = 2'b11
   } rmode_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } state_e;

   typedef struct packed {
      logic              sign;
      logic              nan;
      logic              ovf;
      logic              left;
      logic [CNT_W-1:0]  cnt;
      logic [INT_W-1:0]  acc;
      logic              grd;
      logic              stk;
   } unpk_t;

endpackage

// File: rtl/fp2i_unpack.sv
module fp2i_unpack
   import fp2i_pkg::*;
(
   input  logic [FP_W-1:0] op,
   output unpk_t           u
);

   localparam logic signed [EW-1:0] E_TOP  = EW'(INT_W);
   localparam logic signed [EW-1:0] E_FRAC = EW'(FRAC_W);
   localparam logic signed [EW-1:0] E_HALF = EW'(-1);
   localparam logic signed [EW-1:0] E_BIAS = EW'(BIAS);

   logic [EXP_W-1:0]       bexp;
   logic [FRAC_W-1:0]      frac;
   logic signed [EW-1:0]   e_unb;

   assign bexp  = op[FP_W-2 -: EXP_W];
   assign frac  = op[FRAC_W-1:0];
   assign e_unb = $signed({2'b00, bexp}) - E_BIAS;

   always_comb begin
      u      = '0;
      u.sign = op[FP_W-1];
      if (&bexp) begin
         u.nan = |frac;
         u.ovf = ~|frac;
      end else if (bexp == '0) begin
         u.stk = |frac;
      end else if (e_unb >= E_TOP) begin
         u.ovf = 1'b1;
      end else if (e_unb < E_HALF) begin
         u.stk = 1'b1;
      end else if (e_unb <= E_FRAC) begin
         u.acc  = {{(INT_W-MANT_W){1'b0}}, 1'b1, frac};
         u.cnt  = CNT_W'(E_FRAC - e_unb);
         u.left = 1'b0;
      end else begin
         u.acc  = {{(INT_W-MANT_W){1'b0}}, 1'b1, frac};
         u.cnt  = CNT_W'(e_unb - E_FRAC);
         u.left = 1'b1;
      end
   end

endmodule

// File: rtl/fp2i_shift.sv
module fp2i_shift
   import fp2i_pkg::*;
#(
   parameter int STEP = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [INT_W-1:0]  ld_acc,
   input  logic [CNT_W-1:0]  ld_cnt,
   input  logic              ld_left,
   input  logic              ld_grd,
   input  logic              ld_stk,
   output logic [INT_W-1:0]  acc,
   output logic              grd,
   output logic              stk,
   output logic              idle
);

   logic [INT_W-1:0] acc_q, acc_n;
   logic [CNT_W-1:0] cnt_q, cnt_n;
   logic             left_q;
   logic             g_q, g_n;
   logic             s_q, s_n;

   generate
      if (STEP == 1) begin : g_single
         always_comb begin
            acc_n = acc_q;
            cnt_n = cnt_q;
            g_n   = g_q;
            s_n   = s_q;
            if (cnt_q != '0) begin
               if (left_q) begin
                  acc_n = acc_q << 1;
               end else begin
                  s_n   = s_q | g_q;
                  g_n   = acc_q[0];
                  acc_n = acc_q >> 1;
               end
               cnt_n = cnt_q - CNT_W'(1);
            end
         end
      end else begin : g_multi
         always_comb begin
            acc_n = acc_q;
            cnt_n = cnt_q;
            g_n   = g_q;
            s_n   = s_q;
            for (int i = 0; i < STEP; i++) begin
               if (cnt_n != '0) begin
                  if (left_q) begin
                     acc_n = acc_n << 1;
                  end else begin
                     s_n   = s_n | g_n;
                     g_n   = acc_n[0];
                     acc_n = acc_n >> 1;
                  end
                  cnt_n = cnt_n - CNT_W'(1);
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         cnt_q  <= '0;
         left_q <= 1'b0;
         g_q    <= 1'b0;
         s_q    <= 1'b0;
      end else if (load) begin
         acc_q  <= ld_acc;
         cnt_q  <= ld_cnt;
         left_q <= ld_left;
         g_q    <= ld_grd;
         s_q    <= ld_stk;
      end else begin
         acc_q  <= acc_n;
         cnt_q  <= cnt_n;
         g_q    <= g_n;
         s_q    <= s_n;
      end
   end

   assign acc  = acc_q;
   assign grd  = g_q;
   assign stk  = s_q;
   assign idle = (cnt_q == '0);

endmodule

// File: rtl/fp2i_round.sv
module fp2i_round
   import fp2i_pkg::*;
(
   input  logic             sign,
   input  logic [INT_W-1:0] mag,
   input  logic             grd,
   input  logic             stk,
   input  logic             nan,
   input  logic             ovf,
   input  logic [1:0]       fmt,
   input  logic             trunc,
   input  logic [1:0]       rmode,
   output logic [INT_W-1:0] res,
   output logic             inexact,
   output logic             invalid
);

   logic             inc;
   logic             lost;
   logic             is_signed;
   logic [INT_W:0]   rnd;
   logic [INT_W:0]   lim_pos;
   logic [INT_W:0]   lim_neg;
   logic [INT_W-1:0] sat_max;
   logic [INT_W-1:0] sat_min;
   logic             out_rng;

   assign lost      = grd | stk;
   assign is_signed = ~fmt[0];

   always_comb begin
      inc = 1'b0;
      if (!trunc) begin
         case (rmode)
            RM_NEAR: inc = grd & (stk | mag[0]);
            RM_UP:   inc = ~sign & lost;
            RM_DOWN: inc = sign & lost;
            default: inc = 1'b0;
         endcase
      end
   end

   always_comb begin
      case (fmt)
         FMT_S32: sat_max = {INT_W{1'b1}} >> (HALF_W + 1);
         FMT_U32: sat_max = {INT_W{1'b1}} >> HALF_W;
         FMT_S64: sat_max = {INT_W{1'b1}} >> 1;
         default: sat_max = {INT_W{1'b1}};
      endcase
   end

   assign sat_min = is_signed ? ~sat_max : '0;
   assign rnd     = {1'b0, mag} + {{INT_W{1'b0}}, inc};
   assign lim_pos = {1'b0, sat_max};
   assign lim_neg = is_signed ? lim_pos + (INT_W+1)'(1) : '0;
   assign out_rng = ovf | (sign ? (rnd > lim_neg) : (rnd > lim_pos));

   always_comb begin
      invalid = nan | out_rng;
      inexact = ~(nan | out_rng) & lost;
      if (nan)
         res = sat_min;
      else if (out_rng)
         res = sign ? sat_min : sat_max;
      else if (sign)
         res = INT_W'(0) - rnd[INT_W-1:0];
      else
         res = rnd[INT_W-1:0];
   end

endmodule

// File: rtl/fp2i_convert.sv
module fp2i_convert
   import fp2i_pkg::*;
#(
   parameter int STEP = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic [63:0] op,
   input  logic [1:0]  fmt,
   input  logic        trunc,
   input  logic [1:0]  rmode,
   output logic        busy,
   output logic        done,
   output logic [63:0] result,
   output logic        inexact,
   output logic        invalid
);

   generate
      if (STEP < 1 || STEP > 16) begin : g_bad_step
         $error("fp2i_convert: STEP must lie in 1..16");
      end
      if (INT_W != 64 || FP_W != 64) begin : g_bad_width
         $error("fp2i_convert: port widths assume 64-bit operand and result");
      end
   endgenerate

   state_e           state_q;
   logic             accept;
   logic [1:0]       fmt_q;
   logic             trunc_q;
   logic [1:0]       rm_q;
   logic             sign_q;
   logic             nan_q;
   logic             ovf_q;
   unpk_t            u;
   logic [INT_W-1:0] sh_acc;
   logic             sh_grd;
   logic             sh_stk;
   logic             sh_idle;
   logic [INT_W-1:0] rr_res;
   logic             rr_x;
   logic             rr_v;

   assign accept = (state_q == ST_IDLE) && start;
   assign busy   = (state_q == ST_RUN);

   fp2i_unpack u_unpack (
      .op (op),
      .u  (u)
   );

   fp2i_shift #(.STEP(STEP)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .ld_acc  (u.acc),
      .ld_cnt  (u.cnt),
      .ld_left (u.left),
      .ld_grd  (u.grd),
      .ld_stk  (u.stk),
      .acc     (sh_acc),
      .grd     (sh_grd),
      .stk     (sh_stk),
      .idle    (sh_idle)
   );

   fp2i_round u_round (
      .sign    (sign_q),
      .mag     (sh_acc),
      .grd     (sh_grd),
      .stk     (sh_stk),
      .nan     (nan_q),
      .ovf     (ovf_q),
      .fmt     (fmt_q),
      .trunc   (trunc_q),
      .rmode   (rm_q),
      .res     (rr_res),
      .inexact (rr_x),
      .invalid (rr_v)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         fmt_q   <= '0;
         trunc_q <= 1'b0;
         rm_q    <= '0;
         sign_q  <= 1'b0;
         nan_q   <= 1'b0;
         ovf_q   <= 1'b0;
         done    <= 1'b0;
         result  <= '0;
         inexact <= 1'b0;
         invalid <= 1'b0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            state_q <= ST_RUN;
            fmt_q   <= fmt;
            trunc_q <= trunc;
            rm_q    <= rmode;
            sign_q  <= u.sign;
            nan_q   <= u.nan;
            ovf_q   <= u.ovf;
         end else if (busy && sh_idle) begin
            state_q <= ST_IDLE;
            done    <= 1'b1;
            result  <= rr_res;
            inexact <= rr_x;
            invalid <= rr_v;
         end
      end
   end

endmodule

// File: rtl/fp2i_convert_chk.sv
module fp2i_convert_chk
   import fp2i_pkg::*;
#(
   parameter int STEP = 4
) (
   input logic        clk,
   input logic        rst_n,
   input logic        start,
   input logic        busy,
   input logic        done,
   input logic [63:0] result,
   input logic        inexact,
   input logic        invalid,
   input logic [1:0]  fmt_q,
   input logic        nan_q
);

   localparam int LIM = (MAX_SHIFT + STEP - 1) / STEP + 1;

   int busy_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         busy_run <= 0;
      else
         busy_run <= busy ? busy_run + 1 : 0;
   end

   p_flags_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !(inexact && invalid));

   p_nan_invalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && nan_q) |-> (invalid && !inexact));

   p_sext32_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fmt_q == FMT_S32) |-> (result[63:32] == {32{result[31]}}));

   p_zext32_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fmt_q == FMT_U32) |-> (result[63:32] == 32'h0));

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) && !busy));

   p_busy_from_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   p_busy_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy_run <= LIM);

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(result) && $stable(inexact) && $stable(invalid)));

endmodule

bind fp2i_convert fp2i_convert_chk #(.STEP(STEP)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .done    (done),
   .result  (result),
   .inexact (inexact),
   .invalid (invalid),
   .fmt_q   (fmt_q),
   .nan_q   (nan_q)
);

// File: tb/tb_fp2i_convert.sv
module tb_fp2i_convert;

   localparam int CLK_NS = 10;
   localparam int STEP   = 4;
   localparam int LAT    = (53 + STEP - 1) / STEP + 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [63:0] op = '0;
   logic [1:0]  fmt = '0;
   logic        trunc = 1'b0;
   logic [1:0]  rmode = '0;
   logic        busy, done, inexact, invalid;
   logic [63:0] result;

   int checks = 0;
   int fails  = 0;

   always #(CLK_NS/2) clk = ~clk;

   fp2i_convert #(.STEP(STEP)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .fmt(fmt),
      .trunc(trunc), .rmode(rmode), .busy(busy), .done(done),
      .result(result), .inexact(inexact), .invalid(invalid)
   );

   typedef struct packed {
      logic [63:0] op;
      logic [1:0]  fmt;
      logic        trunc;
      logic [1:0]  rm;
      logic [63:0] res;
      logic        x;
      logic        v;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 32;
   // fmt 0 s32, 1 u32, 2 s64, 3 u64; rm 0 near, 1 zero, 2 up, 3 down
   localparam vec_t VECS [NV] = '{
      '{64'h4004000000000000, 2'd0, 1'b0, 2'd0, 64'h0000000000000002, 1'b1, 1'b0, 8'd2},  // R2 2.5 tie even
      '{64'h400C000000000000, 2'd0, 1'b0, 2'd0, 64'h0000000000000004, 1'b1, 1'b0, 8'd2},  // R2 3.5 tie even
      '{64'h4004000000000000, 2'd0, 1'b1, 2'd2, 64'h0000000000000002, 1'b1, 1'b0, 8'd1},  // R1 trunc wins
      '{64'hC004000000000000, 2'd0, 1'b0, 2'd3, 64'hFFFFFFFFFFFFFFFD, 1'b1, 1'b0, 8'd2},  // R2 -2.5 down
      '{64'hC004000000000000, 2'd0, 1'b0, 2'd2, 64'hFFFFFFFFFFFFFFFE, 1'b1, 1'b0, 8'd2},  // R2 -2.5 up
      '{64'h3FF0000000000000, 2'd3, 1'b0, 2'd0, 64'h0000000000000001, 1'b0, 1'b0, 8'd5},  // R5 exact 1
      '{64'h0000000000000000, 2'd2, 1'b0, 2'd0, 64'h0000000000000000, 1'b0, 1'b0, 8'd5},  // R5 zero
      '{64'hBFE0000000000000, 2'd1, 1'b0, 2'd0, 64'h0000000000000000, 1'b1, 1'b0, 8'd4},  // R4 -0.5 u32
      '{64'h3FE8000000000000, 2'd1, 1'b0, 2'd3, 64'h0000000000000000, 1'b1, 1'b0, 8'd2},  // R2 0.75 down
      '{64'hBFE0000000000000, 2'd1, 1'b0, 2'd3, 64'h0000000000000000, 1'b0, 1'b1, 8'd3},  // R3 -0.5 -> -1 u32
      '{64'hBFF0000000000000, 2'd3, 1'b0, 2'd0, 64'h0000000000000000, 1'b0, 1'b1, 8'd3},  // R3 -1 u64
      '{64'h41E0000000000000, 2'd0, 1'b0, 2'd0, 64'h000000007FFFFFFF, 1'b0, 1'b1, 8'd3},  // R3 2^31 s32
      '{64'h41E0000000000000, 2'd1, 1'b0, 2'd0, 64'h0000000080000000, 1'b0, 1'b0, 8'd7},  // R7 2^31 u32
      '{64'hC1E0000000000000, 2'd0, 1'b0, 2'd0, 64'hFFFFFFFF80000000, 1'b0, 1'b0, 8'd7},  // R7 -2^31 s32
      '{64'h41DFFFFFFFE00000, 2'd0, 1'b0, 2'd0, 64'h000000007FFFFFFF, 1'b0, 1'b1, 8'd3},  // R3 rounds over
      '{64'h41DFFFFFFFE00000, 2'd0, 1'b1, 2'd0, 64'h000000007FFFFFFF, 1'b1, 1'b0, 8'd5},  // R5 trunc fits
      '{64'h41EFFFFFFFF00000, 2'd1, 1'b0, 2'd0, 64'h00000000FFFFFFFF, 1'b0, 1'b1, 8'd3},  // R3 u32 over
      '{64'h7FF8000000000000, 2'd2, 1'b0, 2'd0, 64'h8000000000000000, 1'b0, 1'b1, 8'd6},  // R6 NaN s64
      '{64'h7FF8000000000000, 2'd1, 1'b0, 2'd0, 64'h0000000000000000, 1'b0, 1'b1, 8'd6},  // R6 NaN u32
      '{64'h7FF8000000000000, 2'd0, 1'b0, 2'd0, 64'hFFFFFFFF80000000, 1'b0, 1'b1, 8'd6},  // R6 NaN s32
      '{64'h7FF0000000000000, 2'd3, 1'b0, 2'd0, 64'hFFFFFFFFFFFFFFFF, 1'b0, 1'b1, 8'd3},  // R3 +inf u64
      '{64'hFFF0000000000000, 2'd0, 1'b0, 2'd0, 64'hFFFFFFFF80000000, 1'b0, 1'b1, 8'd3},  // R3 -inf s32
      '{64'h43E0000000000000, 2'd2, 1'b0, 2'd0, 64'h7FFFFFFFFFFFFFFF, 1'b0, 1'b1, 8'd3},  // R3 2^63 s64
      '{64'h43E0000000000000, 2'd3, 1'b0, 2'd0, 64'h8000000000000000, 1'b0, 1'b0, 8'd1},  // R1 2^63 u64
      '{64'hC3E0000000000000, 2'd2, 1'b0, 2'd0, 64'h8000000000000000, 1'b0, 1'b0, 8'd1},  // R1 -2^63 s64
      '{64'h43EFFFFFFFFFFFFF, 2'd3, 1'b0, 2'd0, 64'hFFFFFFFFFFFFF800, 1'b0, 1'b0, 8'd1},  // R1 max left shift
      '{64'h0000000000000001, 2'd2, 1'b0, 2'd2, 64'h0000000000000001, 1'b1, 1'b0, 8'd2},  // R2 denormal up
      '{64'h8000000000000001, 2'd2, 1'b0, 2'd3, 64'hFFFFFFFFFFFFFFFF, 1'b1, 1'b0, 8'd2},  // R2 -denormal down
      '{64'h8000000000000001, 2'd3, 1'b0, 2'd3, 64'h0000000000000000, 1'b0, 1'b1, 8'd3},  // R3 -denormal u64
      '{64'h3FF8000000000000, 2'd3, 1'b1, 2'd2, 64'h0000000000000001, 1'b1, 1'b0, 8'd1},  // R1 trunc 1.5
      '{64'h3FF8000000000000, 2'd3, 1'b0, 2'd0, 64'h0000000000000002, 1'b1, 1'b0, 8'd2},  // R2 1.5 near
      '{64'hBFF8000000000000, 2'd2, 1'b0, 2'd1, 64'hFFFFFFFFFFFFFFFF, 1'b1, 1'b0, 8'd2}   // R2 -1.5 zero
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic launch(input logic [63:0] o, input logic [1:0] f,
                         input logic t, input logic [1:0] r);
      @(negedge clk);
      op = o; fmt = f; trunc = t; rmode = r; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(output int cyc);
      cyc = 0;
      while (!done && cyc < 500) begin
         @(negedge clk);
         cyc++;
      end
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R8: done missing, actual 0 expected 1");
      end
   endtask

   initial begin
      #(CLK_NS * 150000);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      int cyc;
      // R10 reset state
      #(CLK_NS * 2);
      chk("R10 busy", {63'b0, busy}, 64'h0);
      chk("R10 done", {63'b0, done}, 64'h0);
      chk("R10 result", result, 64'h0);
      chk("R10 flags", {62'b0, inexact, invalid}, 64'h0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         launch(VECS[i].op, VECS[i].fmt, VECS[i].trunc, VECS[i].rm);
         wait_done(cyc);
         chk($sformatf("R%0d vec %0d result", VECS[i].req, i), result, VECS[i].res);
         chk($sformatf("R%0d vec %0d inexact", VECS[i].req, i), {63'b0, inexact}, {63'b0, VECS[i].x});
         chk($sformatf("R%0d vec %0d invalid", VECS[i].req, i), {63'b0, invalid}, {63'b0, VECS[i].v});
      end

      // R8 busy timing at the longest right shift (0.75 needs 53 positions)
      launch(64'h3FE8000000000000, 2'd0, 1'b0, 2'd0);
      chk("R8 busy after start", {63'b0, busy}, 64'h1);
      wait_done(cyc);
      chk("R8 busy low with done", {63'b0, busy}, 64'h0);
      chk("R8 latency bound", {63'b0, (cyc <= LAT)}, 64'h1);
      @(negedge clk);
      chk("R8 done one cycle", {63'b0, done}, 64'h0);

      // R9 start while busy ignored
      launch(64'h4004000000000000, 2'd0, 1'b0, 2'd0);
      op = 64'h4024000000000000; fmt = 2'd2; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(cyc);
      chk("R9 second start ignored", result, 64'h2);
      @(negedge clk);
      chk("R9 no extra done", {63'b0, done}, 64'h0);
      op = 64'h7FF8000000000000;
      repeat (20) @(negedge clk);
      chk("R9 result held", result, 64'h2);
      chk("R9 flags held", {62'b0, inexact, invalid}, 64'h2);
      chk("R9 stays idle", {63'b0, busy}, 64'h0);

      // R10 reset during a conversion
      launch(64'h3FE8000000000000, 2'd0, 1'b0, 2'd0);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R10 reset mid-run busy", {63'b0, busy}, 64'h0);
      chk("R10 reset mid-run result", result, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule